// File: doc/BRIEF.md
# Interlocked Asynchronous Read Master

This block is the initiator side of a four-phase, fully interlocked read on a shared bus. Local logic asks for a read by pulsing a request together with an address while the block is idle. The block then puts the address and the read line on the bus. It waits a configurable number of clock cycles so those lines can settle, and only then raises its master strobe.

The responding side is not clocked by this block. It returns data together with a slave strobe. The slave strobe is brought through a flop synchronizer. On the first cycle that the synchronized strobe is seen high, the block captures the data and lowers its own strobe. It then waits until the slave strobe has gone low again, and only after that removes the read line and the address. The removal is marked by a single-cycle completion pulse. Each step waits for the other party's previous step rather than for a fixed clock count.

If the slave never answers, a cycle counter ends the wait. The transfer is then aborted, an error flag is raised, and the bus lines are still returned to idle in the same order as for a normal transfer.

Top module: `ahs_read_master`

## Requirements
- R1: While reset is asserted and after it is released, `bus_rd_o`, `bus_msyn_o`, `done_o` and `err_o` are low, and `bus_addr_o` and `rdata_o` are zero.
- R2: A request (`req_i` high) is accepted only in the idle state. At the clock edge that samples it, `bus_addr_o` takes `addr_i` and `bus_rd_o` goes high. A request made while a transfer is in progress is ignored and has no effect on the bus address.
- R3: `bus_msyn_o` rises exactly `SETTLE_CYC` clock edges after the edge that raised `bus_rd_o`. `bus_addr_o` does not change while `bus_rd_o` is high.
- R4: `bus_ssyn_i` passes through `SYNC_STAGES` flops before it is used. At the first edge where the synchronized value is high, `bus_data_i` is stored in `rdata_o` and `bus_msyn_o` falls. With the default of two stages, a slave strobe that rises just after edge k is acted on at edge k+3.
- R5: After `bus_msyn_o` falls, `bus_rd_o` and `bus_addr_o` are held until the synchronized slave strobe is seen low. They are then both released (read low, address zero) at one edge.
- R6: `done_o` is high for exactly one cycle, starting at the edge that releases the read line and address, and once per accepted request.
- R7: If the synchronized slave strobe has not been seen high by the `TIMEOUT_CYC`-th edge after `bus_msyn_o` rose, `bus_msyn_o` falls and `err_o` is set at that edge, and `rdata_o` keeps its old value. The release of R5 and the pulse of R6 still follow. `err_o` stays high until the next request is accepted, which clears it.
- R8: If the synchronized slave strobe is first seen high at the same edge that the timeout expires, the response wins: the data is captured and `err_o` stays low.
- R9: `bus_msyn_o` is never high while `bus_rd_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Read request from local logic, sampled in idle |
| addr_i | input | AW | Address for the requested read |
| rdata_o | output | DW | Last captured read data |
| done_o | output | 1 | One-cycle pulse when the bus lines have been released |
| err_o | output | 1 | Set by a timeout abort, cleared by the next accepted request |
| bus_addr_o | output | AW | Address lines driven onto the bus |
| bus_rd_o | output | 1 | Read control line |
| bus_msyn_o | output | 1 | Master strobe: address and read line are valid |
| bus_ssyn_i | input | 1 | Slave strobe: read data is valid (asynchronous) |
| bus_data_i | input | DW | Read data from the slave |

## Verification
Two functions can fall on the same edge: capturing a slave response and expiring the timeout. The bench provokes this with its behavioural slave. The slave raises its strobe `TIMEOUT_CYC - SYNC_STAGES - 1` edges after the master strobe, so the synchronized value first appears at the very edge where the timeout counter expires. At that edge the bench expects the data to be captured with no error. It then moves the response one edge later and expects an abort with the old data kept. A slave that never answers, and a request poked while the master is busy, cover the remaining cases.

// File: rtl/ahs_pkg.sv
package ahs_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SETTLE = 2'd1,
      ST_WAIT   = 2'd2,
      ST_DROP   = 2'd3
   } ahs_state_e;

endpackage

// File: rtl/ahs_sync.sv
module ahs_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   initial begin : p_param_chk
      assert (STAGES >= 2) else $fatal(1, "ahs_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   generate
      for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[gi] <= 1'b0;
               else        chain_q[gi] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[gi] <= 1'b0;
               else        chain_q[gi] <= chain_q[gi-1];
            end
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/ahs_cnt.sv
module ahs_cnt #(
   parameter int LIMIT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic en_i,
   output logic hit_o
);

   localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);

   initial begin : p_param_chk
      assert (LIMIT >= 1) else $fatal(1, "ahs_cnt: LIMIT must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clr_i)  cnt_q <= '0;
      else if (en_i)   cnt_q <= (cnt_q == CW'(LIMIT - 1)) ? '0 : cnt_q + 1'b1;
   end

   assign hit_o = en_i && (cnt_q == CW'(LIMIT - 1));

endmodule

// File: rtl/ahs_read_master.sv
module ahs_read_master
   import ahs_pkg::*;
#(
   parameter int AW          = 16,
   parameter int DW          = 32,
   parameter int SETTLE_CYC  = 2,
   parameter int TIMEOUT_CYC = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_i,
   input  logic [AW-1:0] addr_i,
   output logic [DW-1:0] rdata_o,
   output logic          done_o,
   output logic          err_o,
   output logic [AW-1:0] bus_addr_o,
   output logic          bus_rd_o,
   output logic          bus_msyn_o,
   input  logic          bus_ssyn_i,
   input  logic [DW-1:0] bus_data_i
);

   localparam int MIN_TMO = SYNC_STAGES + 2;

   initial begin : p_param_chk
      assert (AW >= 1 && DW >= 1) else $fatal(1, "ahs_read_master: widths must be positive");
      assert (SETTLE_CYC >= 1) else $fatal(1, "ahs_read_master: SETTLE_CYC must be at least 1");
      assert (TIMEOUT_CYC >= MIN_TMO) else $fatal(1, "ahs_read_master: TIMEOUT_CYC too short for the synchronizer");
   end

   ahs_state_e state_q;
   logic       ssyn_s;
   logic       settle_hit;
   logic       tmo_hit;

   ahs_sync #(.STAGES(SYNC_STAGES)) u_ssyn_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (bus_ssyn_i),
      .q_o   (ssyn_s)
   );

   ahs_cnt #(.LIMIT(SETTLE_CYC)) u_settle_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (state_q != ST_SETTLE),
      .en_i  (state_q == ST_SETTLE),
      .hit_o (settle_hit)
   );

   ahs_cnt #(.LIMIT(TIMEOUT_CYC)) u_tmo_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (state_q != ST_WAIT),
      .en_i  (state_q == ST_WAIT),
      .hit_o (tmo_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         bus_addr_o <= '0;
         bus_rd_o   <= 1'b0;
         bus_msyn_o <= 1'b0;
         rdata_o    <= '0;
         done_o     <= 1'b0;
         err_o      <= 1'b0;
      end else begin
         done_o <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (req_i) begin
                  bus_addr_o <= addr_i;
                  bus_rd_o   <= 1'b1;
                  err_o      <= 1'b0;
                  state_q    <= ST_SETTLE;
               end
            end
            ST_SETTLE: begin
               if (settle_hit) begin
                  bus_msyn_o <= 1'b1;
                  state_q    <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (ssyn_s) begin
                  rdata_o    <= bus_data_i;
                  bus_msyn_o <= 1'b0;
                  state_q    <= ST_DROP;
               end else if (tmo_hit) begin
                  err_o      <= 1'b1;
                  bus_msyn_o <= 1'b0;
                  state_q    <= ST_DROP;
               end
            end
            ST_DROP: begin
               if (!ssyn_s) begin
                  bus_rd_o   <= 1'b0;
                  bus_addr_o <= '0;
                  done_o     <= 1'b1;
                  state_q    <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   AST_MSYN_NEEDS_RD: assert property (@(posedge clk) disable iff (!rst_n)
      bus_msyn_o |-> bus_rd_o); // R9

   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd_o && $past(bus_rd_o)) |-> $stable(bus_addr_o)); // R3

   AST_RELEASE_AFTER_SSYN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_rd_o) |-> !$past(ssyn_s)); // R5

   AST_MSYN_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_msyn_o) |-> ($past(ssyn_s) || err_o)); // R4

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R6

   AST_DONE_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!bus_rd_o && !bus_msyn_o)); // R6

   AST_ERR_ON_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_o) |-> $fell(bus_msyn_o)); // R7

   AST_RESPONSE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAIT && ssyn_s) |=> !err_o); // R8

endmodule

// File: tb/ahs_read_master_tb.sv
`timescale 1ns/1ps
module ahs_read_master_tb;

   localparam int AW   = 12;
   localparam int DW   = 16;
   localparam int SETL = 3;
   localparam int TMO  = 20;
   localparam int SYNC = 2;

   typedef struct packed {
      logic [DW-1:0] data;
      logic          err;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_i = 1'b0;
   logic [AW-1:0] addr_i = '0;
   logic [DW-1:0] rdata_o;
   logic          done_o, err_o;
   logic [AW-1:0] bus_addr_o;
   logic          bus_rd_o, bus_msyn_o;
   logic          bus_ssyn_i = 1'b0;
   logic [DW-1:0] bus_data_i = '0;

   int n_tests = 0;
   int n_fail  = 0;
   int n_done  = 0;
   int sl_delay = 0;
   int sl_rel   = 0;
   logic [AW-1:0] cur_addr = '0;
   logic [DW-1:0] last_data = '0;
   exp_t sb_q[$];

   always #4 clk = ~clk;

   ahs_read_master #(
      .AW(AW), .DW(DW), .SETTLE_CYC(SETL), .TIMEOUT_CYC(TMO), .SYNC_STAGES(SYNC)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .addr_i(addr_i),
      .rdata_o(rdata_o), .done_o(done_o), .err_o(err_o),
      .bus_addr_o(bus_addr_o), .bus_rd_o(bus_rd_o), .bus_msyn_o(bus_msyn_o),
      .bus_ssyn_i(bus_ssyn_i), .bus_data_i(bus_data_i)
   );

   function automatic logic [DW-1:0] slave_word(input logic [AW-1:0] a);
      return DW'(a) * 16'd9 + 16'h1234;
   endfunction

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: %s actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   // Behavioural slave with programmable response and release delay
   initial begin : p_slave
      forever begin
         wait (bus_msyn_o === 1'b1);
         if (sl_delay >= 0) begin
            repeat (sl_delay) @(posedge clk);
            #1;
            chk(bus_rd_o === 1'b1 && bus_msyn_o === 1'b1, "R3", "read/strobe at response",
                {bus_rd_o, bus_msyn_o}, 2'b11);
            chk(bus_addr_o === cur_addr, "R2", "bus address at response", bus_addr_o, cur_addr);
            chk(err_o === 1'b0, "R7", "error cleared by new request", err_o, 0);
            bus_data_i = slave_word(bus_addr_o);
            bus_ssyn_i = 1'b1;
         end
         wait (bus_msyn_o === 1'b0);
         if (bus_ssyn_i) begin
            repeat (sl_rel) @(posedge clk);
            #1;
            bus_ssyn_i = 1'b0;
            bus_data_i = '0;
         end
      end
   end

   // Settle-time and strobe ordering monitor
   int  rd_cnt = 0;
   logic prev_rd = 1'b0, prev_msyn = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (bus_rd_o && !prev_rd) rd_cnt = 0;
         else if (bus_rd_o)        rd_cnt++;
         if (bus_msyn_o && !prev_msyn) begin
            chk(rd_cnt == SETL, "R3", "cycles from read to strobe", rd_cnt, SETL);
            chk(bus_rd_o === 1'b1, "R9", "read high with strobe", bus_rd_o, 1);
         end
         if (done_o) begin
            n_done++;
            chk(prev_rd === 1'b1 && bus_rd_o === 1'b0 && bus_addr_o === '0, "R5",
                "release at done", {prev_rd, bus_rd_o, bus_addr_o}, {2'b10, AW'(0)});
            chk(bus_ssyn_i === 1'b0, "R5", "slave strobe low at release", bus_ssyn_i, 0);
            if (sb_q.size() == 0) begin
               chk(1'b0, "R6", "unexpected done pulse", 1, 0);
            end else begin
               exp_t e;
               e = sb_q.pop_front();
               chk(err_o === e.err, "R7", "error flag", err_o, e.err);
               chk(rdata_o === e.data, "R4", "read data", rdata_o, e.data);
            end
         end
         prev_rd   = bus_rd_o;
         prev_msyn = bus_msyn_o;
      end
   end

   task automatic rd_txn(input logic [AW-1:0] a, input int dly, input int rel, input bit poke);
      exp_t e;
      int start;
      int w;
      bit fails;
      fails = (dly < 0) || (dly + SYNC + 1 > TMO);
      e.err  = fails;
      e.data = fails ? last_data : slave_word(a);
      if (!fails) last_data = slave_word(a);
      sl_delay = dly;
      sl_rel   = rel;
      cur_addr = a;
      sb_q.push_back(e);
      start = n_done;
      @(negedge clk); req_i = 1'b1; addr_i = a;
      @(negedge clk); req_i = 1'b0; addr_i = '0;
      if (poke) begin
         @(negedge clk); req_i = 1'b1; addr_i = ~a;   // R2: ignored while busy
         @(negedge clk); req_i = 1'b0; addr_i = '0;
      end
      w = 0;
      while (n_done == start && w < 2000) begin
         @(negedge clk);
         w++;
      end
      chk(n_done == start + 1, "R6", "one done per request", n_done - start, 1);
      repeat (3) @(negedge clk);
      chk(n_done == start + 1 && !done_o, "R6", "no extra done", n_done - start, 1);
   endtask

   initial begin : p_watchdog
      repeat (100000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : p_main
      repeat (3) @(negedge clk);
      chk({bus_rd_o, bus_msyn_o, done_o, err_o} === 4'b0 && bus_addr_o === '0 && rdata_o === '0,
          "R1", "outputs in reset", {bus_rd_o, bus_msyn_o, done_o, err_o}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk({bus_rd_o, bus_msyn_o, done_o, err_o} === 4'b0 && bus_addr_o === '0,
          "R1", "outputs after reset", {bus_rd_o, bus_msyn_o, done_o, err_o}, 0);

      rd_txn(12'h0A5, 0, 0, 1'b0);            // R4 fastest slave
      rd_txn(12'h3C1, 5, 3, 1'b0);            // R5 slow release
      rd_txn(12'h7FE, 2, 1, 1'b1);            // R2 request while busy
      rd_txn(12'h123, TMO - SYNC - 1, 0, 1'b0); // R8 response meets timeout edge
      rd_txn(12'h456, TMO - SYNC, 2, 1'b0);   // R7 response one edge too late
      rd_txn(12'h789, -1, 0, 1'b0);           // R7 no response
      rd_txn(12'hFFF, 1, 0, 1'b0);            // R7 error cleared, normal read
      chk(sb_q.size() == 0, "R6", "scoreboard drained", sb_q.size(), 0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule